// File: doc/BRIEF.md
# Thermometer Attenuator Controller with Fast-Attack Offset

This block drives a step attenuator built from identical 0.5 dB cells. A register supplies a 6-bit gain code and a 2-bit fast-attack step select. A pin from outside the clock domain requests an extra, temporary cut in gain. From these inputs the block computes how many cells must be switched in and presents that count as a registered thermometer vector. Code zero means no cells and full gain. Each further code value switches in one more cell.

Because the vector is thermometer-coded and comes straight from flops, a change in setting moves the output directly from the old vector to the new one. Only the cells that differ between the two settings toggle, and the output never passes through an intermediate code. An enable input puts the controller to sleep. While asleep, the attenuator state is frozen and a power-down flag is raised for the analog section.

Top module: `atten_therm_ctrl`

## Requirements
- R1: A gain code n in the range 0 to 40 produces exactly n ones in the thermometer output, filling from bit 0 upward, while the fast-attack pin is low.
- R2: Any gain code from 41 to 63 produces 40 ones, which is the full vector and the lowest gain.
- R3: While the synchronised fast-attack pin is high, the cell count becomes the clamped gain count plus an offset chosen by the step select (0 gives 4 cells, 1 gives 8, 2 gives 16, 3 gives 32). The sum saturates at 40.
- R4: Once the fast-attack pin returns low, the output returns to the count set by the gain code alone.
- R5: The output always has thermometer form: all ones sit contiguously from bit 0 and every bit above them is zero.
- R6: When the setting changes, every sampled output equals either the old vector or the new one, never a third value.
- R7: A rising or falling fast-attack pin is reflected in the output at the third rising clock edge after it changes (two synchroniser flops plus the output register). This is 20 ns at a 150 MHz clock.
- R8: While enable is low, the thermometer output holds its last value, even if the gain code, the step select or the fast-attack pin change.
- R9: `power_down` is 1 on the clock edge after enable was sampled low, and 0 on the edge after enable was sampled high.
- R10: During reset the thermometer output is all zeros and `power_down` is 1.
- R11: A new gain code or step select is captured at the first clock edge and appears in the output at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gain_code | input | 6 | Programmed gain code, 0.5 dB of attenuation per step |
| fa_step | input | 2 | Fast-attack offset select |
| fa_pin | input | 1 | Asynchronous fast-attack request |
| enable | input | 1 | High for operation, low for sleep |
| atten_therm | output | 40 | Thermometer control vector, one bit per cell |
| power_down | output | 1 | Sleep flag for the analog section |

## Verification
The assertions check the following on every clock cycle:
- The output keeps its thermometer shape.
- The output stays frozen and the power-down flag follows enable while the block is disabled.
- An oversized code fills the whole vector.
- With fast attack off and the code in range, the number of set cells equals the captured code.

Some behaviour can only be shown by the bench scenarios:
- The exact fast-attack offset for each step select, and saturation when a large code is combined with a large offset.
- The precise edge at which a pin change or a register change reaches the output.
- The absence of intermediate values during a large jump in setting.

// File: rtl/atc_pkg.sv
package atc_pkg;

  // Clamp the programmed code to the number of cells that exist.
  function automatic int clamp_cells(input int code, input int limit);
    return (code > limit) ? limit : code;
  endfunction

  // Fast-attack offset in cells: base doubled per select step.
  function automatic int fa_offset_cells(input int sel, input int base);
    return base << sel;
  endfunction

  // Saturating sum of two cell counts.
  function automatic int sat_sum(input int a, input int b, input int limit);
    int s;
    s = a + b;
    return (s > limit) ? limit : s;
  endfunction

endpackage

// File: rtl/atc_cfg_capture.sv
module atc_cfg_capture #(
  parameter int CODE_W = 6,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] gain_code_i,
  input  logic [SEL_W-1:0]  fa_step_i,
  output logic [CODE_W-1:0] gain_q,
  output logic [SEL_W-1:0]  step_q
);

  // One register stage: a register write is seen the following cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      step_q <= '0;
    end else begin
      gain_q <= gain_code_i;
      step_q <= fa_step_i;
    end
  end

endmodule

// File: rtl/atc_sync.sv
module atc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/atc_cell_count.sv
module atc_cell_count #(
  parameter int NCELLS  = 40,
  parameter int CODE_W  = 6,
  parameter int SEL_W   = 2,
  parameter int FA_BASE = 4,
  parameter int CNT_W   = $clog2(NCELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] gain_q,
  input  logic [SEL_W-1:0]  step_q,
  input  logic              fa_on,
  output logic [CNT_W-1:0]  cells,
  output logic              code_clamped,
  output logic              sum_saturated
);
  import atc_pkg::*;

  int base_cells;
  int extra_cells;
  int raw_sum;
  int total_cells;

  always_comb begin
    base_cells  = clamp_cells(int'(gain_q), NCELLS);
    extra_cells = fa_on ? fa_offset_cells(int'(step_q), FA_BASE) : 0;
    raw_sum     = base_cells + extra_cells;
    total_cells = sat_sum(base_cells, extra_cells, NCELLS);
    cells       = CNT_W'(total_cells);
  end

  // Named events for the checks.
  assign code_clamped  = (int'(gain_q) > NCELLS);
  assign sum_saturated = (raw_sum > NCELLS);

  // R2, R3: the count never exceeds the number of cells.
  a_r2_count_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cells) <= NCELLS);

  // R3: saturation implies the full count.
  a_r3_sat_full: assert property (@(posedge clk) disable iff (!rst_n)
    sum_saturated |-> (int'(cells) == NCELLS));

endmodule

// File: rtl/atc_therm_reg.sv
module atc_therm_reg #(
  parameter int NCELLS = 40,
  parameter int CNT_W  = $clog2(NCELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  cells,
  output logic [NCELLS-1:0] therm_q,
  output logic              power_down
);

  logic [NCELLS-1:0] therm_next;
  logic              upd_fire;

  generate
    for (genvar i = 0; i < NCELLS; i++) begin : g_cell
      assign therm_next[i] = (int'(cells) > i);
    end
  endgenerate

  assign upd_fire = enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      therm_q    <= '0;
      power_down <= 1'b1;
    end else begin
      power_down <= ~enable;
      if (upd_fire) therm_q <= therm_next;
    end
  end

  // R5: ones are contiguous from bit 0.
  a_r5_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm_q & (therm_q + 1'b1)) == '0));

  // R8: frozen while asleep.
  a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(therm_q));

  // R9: power-down flag follows enable one edge later.
  a_r9_pd_set: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> power_down);

  a_r9_pd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> !power_down);

endmodule

// File: rtl/atten_therm_ctrl.sv
module atten_therm_ctrl #(
  parameter int NCELLS      = 40,
  parameter int CODE_W      = 6,
  parameter int SEL_W       = 2,
  parameter int FA_BASE     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] gain_code,
  input  logic [SEL_W-1:0]  fa_step,
  input  logic              fa_pin,
  input  logic              enable,
  output logic [NCELLS-1:0] atten_therm,
  output logic              power_down
);

  localparam int CNT_W = $clog2(NCELLS + 1);

  logic [CODE_W-1:0] gain_q;
  logic [SEL_W-1:0]  step_q;
  logic              fa_on;
  logic [CNT_W-1:0]  cells;
  logic              code_clamped;
  logic              sum_saturated;

  atc_cfg_capture #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .gain_code_i (gain_code),
    .fa_step_i   (fa_step),
    .gain_q      (gain_q),
    .step_q      (step_q)
  );

  atc_sync #(.STAGES(SYNC_STAGES)) u_fa_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (fa_pin),
    .sync_o  (fa_on)
  );

  atc_cell_count #(
    .NCELLS (NCELLS), .CODE_W(CODE_W), .SEL_W(SEL_W),
    .FA_BASE(FA_BASE), .CNT_W(CNT_W)
  ) u_count (
    .clk           (clk),
    .rst_n         (rst_n),
    .gain_q        (gain_q),
    .step_q        (step_q),
    .fa_on         (fa_on),
    .cells         (cells),
    .code_clamped  (code_clamped),
    .sum_saturated (sum_saturated)
  );

  atc_therm_reg #(.NCELLS(NCELLS), .CNT_W(CNT_W)) u_therm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cells      (cells),
    .therm_q    (atten_therm),
    .power_down (power_down)
  );

  // R2: an oversized captured code fills the whole vector.
  a_r2_clamp_full: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && code_clamped) |=> (&atten_therm));

  // R1, R4: without fast attack, the cell count matches the captured code.
  a_r4_plain_count: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fa_on && !code_clamped) |=>
      ($countones(atten_therm) == int'($past(gain_q))));

  // R3: fast attack always applies at least the smallest offset.
  a_r3_fa_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fa_on) |=> ($countones(atten_therm) >= FA_BASE));

endmodule

// File: tb/atten_therm_ctrl_tb.sv
module atten_therm_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 40;

  typedef struct {
    int    cells;
    int    alt;
    logic  pd;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   gain_code = '0;
  logic [1:0]   fa_step = '0;
  logic         fa_pin = 1'b0;
  logic         enable = 1'b0;
  logic [N-1:0] atten_therm;
  logic         power_down;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  atten_therm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .gain_code(gain_code), .fa_step(fa_step),
    .fa_pin(fa_pin), .enable(enable), .atten_therm(atten_therm),
    .power_down(power_down)
  );

  // Reference model, written independently of the RTL.
  function automatic int model_cells(int g, int s, bit f);
    int base;
    int add;
    base = g;
    if (base > N) base = N;
    add = 0;
    if (f) begin
      case (s)
        0: add = 4;
        1: add = 8;
        2: add = 16;
        default: add = 32;
      endcase
    end
    if (base + add > N) return N;
    return base + add;
  endfunction

  function automatic logic [N-1:0] vec_of(int n);
    logic [N-1:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic expect_now(int cells, int alt, logic pd, string tag);
    exp_t e;
    e.cells = cells; e.alt = alt; e.pd = pd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_in(int g, int s, bit f, bit e);
    @(negedge clk);
    gain_code = 6'(g); fa_step = 2'(s); fa_pin = f; enable = e;
  endtask

  task automatic settle(int g, int s, bit f, int ncyc, string tag);
    set_in(g, s, f, 1'b1);
    repeat (ncyc) @(negedge clk);
    expect_now(model_cells(g, s, f), -1, 1'b0, tag);
  endtask

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    exp_t it;
    logic [N-1:0] ev;
    logic [N-1:0] ea;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      n_vec++;
      ev = vec_of(it.cells);
      ea = (it.alt >= 0) ? vec_of(it.alt) : ev;
      if (!((atten_therm == ev) || (atten_therm == ea)) || (power_down !== it.pd)) begin
        n_bad++;
        $display("FAIL %s: therm=%h pd=%0b expected therm=%h (or %h) pd=%0b",
                 it.tag, atten_therm, power_down, ev, ea, it.pd);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now(0, -1, 1'b1, "R10 reset state");
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now(0, -1, 1'b1, "R9 asleep after reset");

    // R9: enable wakes, code 0 gives no cells
    settle(0, 0, 0, 3, "R9 enable gain0");
    settle(1, 0, 0, 3, "R1 gain1");
    settle(17, 0, 0, 3, "R1 gain17");
    settle(40, 0, 0, 3, "R1 gain40 full");
    settle(41, 0, 0, 3, "R2 gain41 clamp");
    settle(63, 0, 0, 3, "R2 gain63 clamp");

    // R3: every step select at gain 10, then saturation cases
    for (int s = 0; s < 4; s++) settle(10, s, 1, 5, "R3 offset select");
    settle(30, 1, 1, 5, "R3 sum 38");
    settle(30, 2, 1, 5, "R3 saturate");
    settle(63, 3, 1, 5, "R3 clamp plus offset");
    settle(30, 2, 0, 5, "R4 release");

    // R7: fast-attack rise latency, then fall latency
    settle(10, 0, 0, 5, "R7 base");
    set_in(10, 0, 1, 1);
    @(negedge clk); expect_now(10, -1, 1'b0, "R7 rise edge1");
    @(negedge clk); expect_now(10, -1, 1'b0, "R7 rise edge2");
    @(negedge clk); expect_now(14, -1, 1'b0, "R7 rise edge3");
    set_in(10, 0, 0, 1);
    @(negedge clk); expect_now(14, -1, 1'b0, "R7 fall edge1");
    @(negedge clk); expect_now(14, -1, 1'b0, "R7 fall edge2");
    @(negedge clk); expect_now(10, -1, 1'b0, "R4 R7 fall edge3");

    // R11: register change latency
    set_in(12, 0, 0, 1);
    @(negedge clk); expect_now(10, -1, 1'b0, "R11 edge1 old");
    @(negedge clk); expect_now(12, -1, 1'b0, "R11 edge2 new");

    // R6: large jump only ever shows the old or the new vector
    settle(5, 0, 0, 3, "R6 start");
    set_in(25, 0, 0, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); expect_now(25, 5, 1'b0, "R6 no intermediate");
    end
    set_in(26, 0, 0, 1);
    @(negedge clk); expect_now(25, -1, 1'b0, "R6 single step hold");
    @(negedge clk); expect_now(26, -1, 1'b0, "R5 R6 single step");

    // R8: sleep freezes output despite input changes
    set_in(26, 0, 0, 0);
    @(negedge clk); expect_now(26, -1, 1'b1, "R9 pd after disable");
    set_in(3, 3, 1, 0);
    repeat (5) @(negedge clk);
    expect_now(26, -1, 1'b1, "R8 hold while asleep");
    set_in(3, 3, 0, 0);
    repeat (5) @(negedge clk);
    expect_now(26, -1, 1'b1, "R8 hold after fa pulse");
    set_in(3, 3, 0, 1);
    @(negedge clk); expect_now(3, -1, 1'b0, "R8 R9 wake applies code");

    wait (q.size() == 0);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule